// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

After the power supply is reported good, this block reads the chip's configuration word one bit at a time. It makes a slow serial strobe from the system clock by dividing it by a parameter (256 by default). It takes the serial data on the system clock edge where the strobe rises. Bits are placed least significant first into a word of `MODE_BITS` bits. Everything runs in the system clock domain: the strobe is only an output, and the capture is a clock enable.

The core reset output stays asserted until the whole word has been captured, even when the external reset was released earlier. After that, the word is frozen and two decodes are available. One is the output drive speed from word bits [14:13]. The other is the enable for the extended bus request/acknowledge and read-return reordering handshake, from word bit 26. If power-good drops at any point, the block discards its progress and starts from bit 0 on the next rising edge of power-good. The external reset is asserted asynchronously and must be released synchronously to the system clock.

Top module: `bootmode_loader`

## Requirements
- R1: While loading, `mode_clk` has a period of exactly `DIV` system clock cycles. In each period it is low for the first `DIV/2` cycles and high for the next `DIV/2`. It is low whenever the block is not loading.
- R2: Loading begins on the first system clock edge at which `pwr_good` is seen high in the idle state. The phase count starts at zero on that edge, so the first rise of `mode_clk` comes `DIV/2` edges later.
- R3: `mode_din` is sampled on each system clock edge at which the phase count goes from `DIV/2-1` to `DIV/2`. The k-th sampled bit (k from 0) ends up in `mode_word[k]`, so the word is filled least significant bit first.
- R4: `load_done` rises on the edge that samples bit `MODE_BITS-1`. Until then, `mode_word` reads all zeros.
- R5: While `load_done` is high and `pwr_good` stays high, `mode_word` does not change, `mode_clk` stays low, and `mode_din` is ignored.
- R6: `core_rst_n` is low until `load_done` is high, whatever the level of `rst_n`. It goes high together with `load_done`.
- R7: A clock edge with `pwr_good` low returns the block to idle. It clears the captured bits, the bit count and `load_done`. The next load starts again from bit 0, so an interrupted load leaves no trace.
- R8: When `load_done` is high, word bits [14:13] equal to 2'b10 drive `drv_fast` high, and 2'b01 drives `drv_slow` high. Codes 2'b00 and 2'b11 leave both low. Both are low while `load_done` is low.
- R9: `ext_hs_en` equals `mode_word[26]` while `load_done` is high, and is low otherwise.
- R10: `rst_n` low clears all state at once, without waiting for a clock edge. `mode_clk`, `load_done`, `core_rst_n`, the decodes and `mode_word` all go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert, synchronous release |
| pwr_good | input | 1 | Supply-stable indication; high starts a load, low aborts or clears |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Serial strobe, system clock divided by DIV |
| mode_word | output | MODE_BITS | Captured configuration word, zero until loading completes |
| load_done | output | 1 | Word fully captured |
| core_rst_n | output | 1 | Core reset, active low, released once loading completes |
| drv_fast | output | 1 | Drive-speed field selects the fastest setting |
| drv_slow | output | 1 | Drive-speed field selects the slowest setting |
| ext_hs_en | output | 1 | Extended bus handshake and return-swap enable |

## Verification
Several words are loaded with different values in the drive-speed field, one with each code. This separates the fast, slow and two neutral decodes, and shows bit 26 both set and clear. The bits in each word are asymmetric, so a reversed bit order or an off-by-one sample position shows up as a wrong word. One load is cut short after ten bits and then restarted with a different word. This shows whether stale bits or a stale count survive an abort. After completion the serial input is toggled freely, which tests the freeze. A reset is applied between clock edges to tell an asynchronous clear from a synchronous one.

// File: rtl/bml_pkg.sv
package bml_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } bml_state_e;

  typedef struct packed {
    logic fast;
    logic slow;
  } drive_sel_t;

  // Drive-speed field: 2'b10 fastest, 2'b01 slowest, others neither.
  function automatic drive_sel_t decode_drive(input logic [1:0] code);
    drive_sel_t r;
    r.fast = (code == 2'b10);
    r.slow = (code == 2'b01);
    return r;
  endfunction

  // Modulo increment used by the strobe divider.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/bml_divider.sv
module bml_divider #(
  parameter int unsigned DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mode_clk,
  output logic sample_evt
);
  import bml_pkg::*;

  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_nx;

  always_comb begin
    phase_nx = CW'(wrap_inc(int'(phase_q), DIV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (run) phase_q <= phase_nx;
    else          phase_q <= '0;
  end

  assign mode_clk   = run && (phase_q >= CW'(HALF));
  assign sample_evt = run && (phase_q == CW'(HALF - 1));

endmodule

// File: rtl/bml_shifter.sv
module bml_shifter #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         last_evt
);
  localparam int unsigned BW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [BW-1:0] nbits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      nbits_q <= '0;
    end else if (clr) begin
      sh_q    <= '0;
      nbits_q <= '0;
    end else if (sample) begin
      sh_q    <= {din, sh_q[W-1:1]};
      nbits_q <= nbits_q + 1'b1;
    end
  end

  assign last_evt = sample && (nbits_q == BW'(W - 1));
  assign word     = sh_q;

endmodule

// File: rtl/bml_ctrl.sv
module bml_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic last_evt,
  output logic loading,
  output logic done
);
  import bml_pkg::*;

  bml_state_e st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    if (!pwr_good) begin
      st_nx = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_nx = ST_LOAD;
        ST_LOAD: if (last_evt) st_nx = ST_DONE;
        ST_DONE: st_nx = ST_DONE;
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  assign loading = (st_q == ST_LOAD);
  assign done    = (st_q == ST_DONE);

endmodule

// File: rtl/bootmode_loader.sv
module bootmode_loader #(
  parameter int unsigned DIV       = 256,
  parameter int unsigned MODE_BITS = 256,
  parameter int unsigned DRV_LSB   = 13,
  parameter int unsigned HS_BIT    = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_good,
  input  logic                 mode_din,
  output logic                 mode_clk,
  output logic [MODE_BITS-1:0] mode_word,
  output logic                 load_done,
  output logic                 core_rst_n,
  output logic                 drv_fast,
  output logic                 drv_slow,
  output logic                 ext_hs_en
);
  import bml_pkg::*;

  // Named internal events, observed by the bound checker.
  logic                 loading;
  logic                 sample_evt;
  logic                 last_evt;
  logic                 done_w;
  logic [MODE_BITS-1:0] raw_word;
  drive_sel_t           drv;

  bml_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .last_evt (last_evt),
    .loading  (loading),
    .done     (done_w)
  );

  bml_divider #(.DIV(DIV)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (loading),
    .mode_clk   (mode_clk),
    .sample_evt (sample_evt)
  );

  bml_shifter #(.W(MODE_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!pwr_good),
    .sample   (sample_evt),
    .din      (mode_din),
    .word     (raw_word),
    .last_evt (last_evt)
  );

  assign mode_word  = done_w ? raw_word : '0;
  assign load_done  = done_w;
  assign core_rst_n = done_w;

  always_comb begin
    drv = decode_drive(mode_word[DRV_LSB+1:DRV_LSB]);
  end

  assign drv_fast  = drv.fast;
  assign drv_slow  = drv.slow;
  assign ext_hs_en = mode_word[HS_BIT];

endmodule

// File: rtl/bml_checker.sv
module bml_checker #(
  parameter int unsigned MODE_BITS = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwr_good,
  input logic                 mode_clk,
  input logic [MODE_BITS-1:0] mode_word,
  input logic                 load_done,
  input logic                 core_rst_n,
  input logic                 drv_fast,
  input logic                 drv_slow,
  input logic                 ext_hs_en,
  input logic                 loading,
  input logic                 sample_evt,
  input logic                 last_evt
);

  AST_STROBE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !loading |-> !mode_clk); // R1

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && pwr_good && !last_evt) |=> $rose(mode_clk)); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_evt && pwr_good) |=> load_done); // R4

  AST_WORD_ZERO_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (mode_word == '0)); // R4

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && pwr_good) |=> (load_done && $stable(mode_word))); // R5

  AST_CORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> !core_rst_n); // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!load_done && !loading && mode_word == '0)); // R7

  AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_fast, drv_slow})); // R8

  AST_HS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> !ext_hs_en); // R9

endmodule

bind bootmode_loader bml_checker #(.MODE_BITS(MODE_BITS)) u_bml_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .mode_clk   (mode_clk),
  .mode_word  (mode_word),
  .load_done  (load_done),
  .core_rst_n (core_rst_n),
  .drv_fast   (drv_fast),
  .drv_slow   (drv_slow),
  .ext_hs_en  (ext_hs_en),
  .loading    (loading),
  .sample_evt (sample_evt),
  .last_evt   (last_evt)
);

// File: tb/bootmode_loader_test.sv
module bootmode_loader_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic mode_din = 1'b0;
  logic mode_clk, load_done, core_rst_n, drv_fast, drv_slow, ext_hs_en;
  logic [W-1:0] mode_word;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  bootmode_loader #(.MODE_BITS(W)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_din(mode_din),
    .mode_clk(mode_clk), .mode_word(mode_word), .load_done(load_done),
    .core_rst_n(core_rst_n), .drv_fast(drv_fast), .drv_slow(drv_slow),
    .ext_hs_en(ext_hs_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phase as an integer, captured bits written by index.
  int m_st = 0;      // 0 idle, 1 loading, 2 complete
  int m_ph = 0;
  int m_nb = 0;
  logic [W-1:0] m_w = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_nb = 0; m_w = '0;
    end else begin
      bit cap;
      cap = (m_st == 1) && (m_ph == 127);
      m_ph = (m_st == 1) ? (m_ph + 1) % 256 : 0;
      if (!pwr_good) begin
        m_st = 0; m_nb = 0; m_w = '0;
      end else if (m_st == 0) begin
        m_st = 1;
      end else if (m_st == 1 && cap) begin
        m_w[m_nb] = mode_din;
        m_nb++;
        if (m_nb == W) m_st = 2;
      end
    end
  end

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    logic e_done;
    logic [W-1:0] e_word;
    cyc++;
    e_done = (m_st == 2);
    e_word = e_done ? m_w : '0;
    chk("R1 mode_clk", mode_clk, (m_st == 1) && (m_ph >= 128));
    chk("R4 load_done", load_done, e_done);
    chk("R3 mode_word", mode_word, e_word);
    chk("R6 core_rst_n", core_rst_n, e_done);
    chk("R8 drv_fast", drv_fast, e_done && e_word[14:13] == 2'b10);
    chk("R8 drv_slow", drv_slow, e_done && e_word[14:13] == 2'b01);
    chk("R9 ext_hs_en", ext_hs_en, e_done && e_word[26]);
  end

  // Strobe period monitor.
  int last_rise = -1;
  logic prev_mclk = 1'b0;
  always @(negedge clk) begin
    if (!pwr_good || !rst_n) last_rise = -1;
    else if (mode_clk && !prev_mclk) begin
      if (last_rise >= 0) chk("R1 strobe period", cyc - last_rise, 256);
      last_rise = cyc;
    end
    prev_mclk = mode_clk;
  end

  task automatic load_word(input logic [W-1:0] v, input int abort_after);
    @(negedge clk);
    mode_din = v[0];
    pwr_good = 1'b1;
    for (int k = 1; k < W; k++) begin
      @(posedge mode_clk);
      if (abort_after == k) begin
        @(negedge clk);
        pwr_good = 1'b0;
        return;
      end
      @(negedge clk);
      mode_din = v[k];
    end
    for (int t = 0; t < 400 && !load_done; t++) @(negedge clk);
  endtask

  task automatic check_done(input logic [W-1:0] v, input logic f, input logic s, input logic h);
    @(negedge clk);
    #1;
    chk("R4 done after load", load_done, 1'b1);
    chk("R3 word lsb first", mode_word, v);
    chk("R8 fast decode", drv_fast, f);
    chk("R8 slow decode", drv_slow, s);
    chk("R9 handshake enable", ext_hs_en, h);
    chk("R6 core released", core_rst_n, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 reset mode_clk", mode_clk, 1'b0);
    chk("R10 reset done", load_done, 1'b0);
    chk("R10 reset core", core_rst_n, 1'b0);
    chk("R10 reset word", mode_word, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk("R6 core held without power-good", core_rst_n, 1'b0);
    chk("R2 idle without power-good", mode_clk, 1'b0);

    // Word A: fast drive, handshake on.
    load_word(32'h8C00_5A5C, -1);
    check_done(32'h8C00_5A5C, 1'b1, 1'b0, 1'b1);

    // Toggle the serial input after completion: nothing may move.
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mode_din = lf[0];
    end
    #1;
    chk("R5 frozen word", mode_word, 32'h8C00_5A5C);
    chk("R5 strobe idle after done", mode_clk, 1'b0);

    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    #1;
    chk("R7 cleared on power loss", mode_word, '0);
    chk("R7 done cleared", load_done, 1'b0);
    repeat (5) @(negedge clk);

    // Word B interrupted after ten bits, then word C loaded from scratch.
    load_word(32'h0000_2001, 10);
    repeat (5) @(negedge clk);
    #1;
    chk("R7 aborted load idle", load_done, 1'b0);
    load_word(32'h7400_E003, -1);
    check_done(32'h7400_E003, 1'b0, 1'b0, 1'b1);

    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    // Word D: slow drive, handshake off.
    load_word(32'h0000_2F0F, -1);
    check_done(32'h0000_2F0F, 1'b0, 1'b1, 1'b0);

    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    // Word E: neutral drive code 00, handshake off.
    load_word(32'hFBFF_9FFF, -1);
    check_done(32'hFBFF_9FFF, 1'b0, 1'b0, 1'b0);

    // Asynchronous reset between edges.
    @(negedge clk);
    #5;
    rst_n = 1'b0;
    #1;
    chk("R10 async clear word", mode_word, '0);
    chk("R10 async clear done", load_done, 1'b0);
    chk("R10 async core reset", core_rst_n, 1'b0);
    chk("R10 async decodes", {drv_fast, drv_slow, ext_hs_en}, 3'b000);
    repeat (3) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule